// File: doc/BRIEF.md
# Cycle-Counting Interrupt Timer

This block raises a processor interrupt after a programmed number of bus cycles. A 16-bit up-counter is loaded through two write-only byte registers on the processor bus. It advances by one on every clock cycle in which the bus-cycle tick input is high, but only while counting is enabled. When the counter rolls over from its all-ones value to zero, the interrupt output goes high and stays high.

The register holding the upper byte also carries the on/off control. A non-zero value loads the upper byte and starts counting. Zero loads a zero upper byte, stops counting and clears a pending interrupt, all in one bus write. Software typically writes the low byte first and then the high byte to arm a countdown of (65536 - value) ticks. It acknowledges the interrupt by writing zero to the high byte.

The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the block leaves reset two clock edges after reset_n rises.

Top module: `cyc_irq_timer`

## Requirements
- R1: While reset is asserted, and after it is released until the first enabling write, irq is 0. Counting is off and the counter value is zero, so ticks alone never raise irq.
- R2: A write to address 0x4100 loads counter bits 7:0 from the data bus. It leaves bits 15:8, the enable state and a pending irq unchanged.
- R3: A write of a non-zero value to address 0x4101 loads counter bits 15:8 from the data bus and enables counting. Bits 7:0 are not changed, and a pending irq stays set.
- R4: A write of 0x00 to address 0x4101 clears counter bits 15:8, disables counting and clears irq. The new values take effect at the same clock edge as the write.
- R5: While enabled, the counter increases by one at each clock edge where the tick input is 1. While disabled, ticks have no effect on the counter.
- R6: When an enabled tick moves the counter from 0xFFFF to 0x0000, irq becomes 1 at that same edge. The counter keeps counting upward from 0x0000 afterwards.
- R7: Once set, irq stays 1 through further ticks, low-byte writes and non-zero high-byte writes. Only a zero write to 0x4101 (or reset) clears it.
- R8: In a cycle with a register write, the written byte takes the bus value and the other byte keeps its value. The tick in that cycle is discarded, with no increment and no wrap.
- R9: Only the exact 16-bit addresses 0x4100 and 0x4101 are decoded. Writes to any other address, including 0x4102 and 0x4001, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| reset_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| cpu_addr | input | 16 | Processor address bus |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Write strobe, one cycle per bus write |
| m2_rise | input | 1 | One-cycle pulse per processor bus cycle (tick) |
| irq | output | 1 | Interrupt request, active high, level |

## Verification
The bench arms the counter at several distances from rollover, from a single tick to 65280 ticks. It checks that irq stays low one tick short of the wrap and goes high exactly on the wrap. An off-by-one compare or a wrong reload byte would move that edge.

Directed cases cover the following. Ticks while disabled must not advance the counter. The counter must continue after the wrap; a design that froze it would need extra ticks to wrap again. The interrupt must survive low-byte and non-zero high-byte writes. A write must beat a tick in the same cycle, or the next wrap arrives one tick early. Near-miss addresses must be ignored; a design with loose decoding would disable itself or reload a byte.

// File: rtl/cit_pkg.sv
package cit_pkg;
  // Default geometry of the timer register file
  localparam int unsigned CIT_ADDR_W = 16;
  localparam int unsigned CIT_DATA_W = 8;
  localparam int unsigned CIT_CNT_W  = 16;
  localparam logic [15:0] CIT_BASE   = 16'h4100;
  localparam int unsigned CIT_SYNC_STAGES = 2;

  // True when a byte-wide bus value is all zeros
  function automatic logic cit_is_zero(input logic [CIT_DATA_W-1:0] v);
    return (v == '0);
  endfunction
endpackage

// File: rtl/cit_rst_sync.sv
module cit_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cit_regdec.sv
module cit_regdec #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BYTES  = 2,
  parameter logic [ADDR_W-1:0] BASE = 16'h4100
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [BYTES-1:0]  byte_we,
  output logic              ctl_wr,
  output logic              ctl_zero
);
  // Byte k of the counter sits at BASE + k; the top byte doubles as control
  for (genvar k = 0; k < BYTES; k++) begin : g_sel
    localparam logic [ADDR_W-1:0] K_ADDR = BASE + ADDR_W'(k);
    assign byte_we[k] = we && (addr == K_ADDR);
  end

  always_comb begin
    ctl_wr   = byte_we[BYTES-1];
    ctl_zero = ctl_wr && (wdata == '0);
  end
endmodule

// File: rtl/cit_counter.sv
module cit_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W/DATA_W-1:0] byte_we,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   run_en,
  input  logic                   tick,
  output logic [CNT_W-1:0]       count,
  output logic                   wrap
);
  localparam int unsigned BYTES = CNT_W / DATA_W;

  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count_d;
  logic             any_we;
  logic             step;

  // Per-byte merge of written data with the held value
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign load_val[b*DATA_W +: DATA_W] =
      byte_we[b] ? wdata : count[b*DATA_W +: DATA_W];
  end

  always_comb begin
    any_we  = |byte_we;
    step    = run_en && tick && !any_we;
    wrap    = step && (&count);
    count_d = count;
    if (any_we) begin
      count_d = load_val;
    end else if (step) begin
      count_d = count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (any_we || step) begin
      count <= count_d;
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|byte_we) && !(run_en && tick)) |=> (count == $past(count)));

  // R5
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tick && !(|byte_we)) |=> (count == CNT_W'($past(count) + CNT_W'(1))));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we[0] && tick) |=> (count[DATA_W-1:0] == $past(wdata)));
endmodule

// File: rtl/cit_ctl.sv
module cit_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_zero,
  input  logic wrap,
  output logic run_en,
  output logic irq
);
  logic run_en_d;
  logic irq_d;

  always_comb begin
    run_en_d = run_en;
    irq_d    = irq;
    if (ctl_wr) begin
      run_en_d = !ctl_zero;
      if (ctl_zero) begin
        irq_d = 1'b0;
      end
    end else if (wrap) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      irq    <= 1'b0;
    end else begin
      run_en <= run_en_d;
      irq    <= irq_d;
    end
  end

  // R4
  zero_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_zero |=> (!irq && !run_en));

  // R3
  nonzero_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_zero) |=> run_en);

  // R6
  wrap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> irq);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctl_zero) |=> irq);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cit_pkg::*;
#(
  parameter int unsigned ADDR_W = CIT_ADDR_W,
  parameter int unsigned DATA_W = CIT_DATA_W,
  parameter int unsigned CNT_W  = CIT_CNT_W,
  parameter logic [ADDR_W-1:0] BASE = CIT_BASE,
  parameter int unsigned SYNC_STAGES = CIT_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              reset_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              m2_rise,
  output logic              irq
);
  localparam int unsigned BYTES = CNT_W / DATA_W;

  logic             rst_n;
  logic [BYTES-1:0] byte_we;
  logic             ctl_wr;
  logic             ctl_zero;
  logic             run_en;
  logic             wrap;
  logic [CNT_W-1:0] count;

  cit_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_async(reset_n), .rst_n_sync(rst_n)
  );

  cit_regdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES(BYTES), .BASE(BASE)) u_dec (
    .addr(cpu_addr), .wdata(cpu_wdata), .we(cpu_we),
    .byte_we(byte_we), .ctl_wr(ctl_wr), .ctl_zero(ctl_zero)
  );

  cit_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .wdata(cpu_wdata),
    .run_en(run_en), .tick(m2_rise), .count(count), .wrap(wrap)
  );

  cit_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_zero(ctl_zero),
    .wrap(wrap), .run_en(run_en), .irq(irq)
  );

  // R2
  low_write_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we[0] && !ctl_wr) |=> (run_en == $past(run_en) && irq == $past(irq)));

  // R9
  decode_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we || (cpu_addr != BASE && cpu_addr != BASE + ADDR_W'(1))) |=> (run_en == $past(run_en)));
endmodule

// File: tb/cyc_irq_timer_bench.sv
module cyc_irq_timer_bench;
  logic        clk = 1'b0;
  logic        reset_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_we;
  logic        m2_rise;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [15:0] LO = 16'h4100;
  localparam logic [15:0] HI = 16'h4101;

  // Vector table: start value and ticks needed to reach the wrap
  localparam int NV = 5;
  localparam logic [15:0] V_START[NV] = '{16'hFFFF, 16'hFFFE, 16'hFF00, 16'hF000, 16'h0100};
  localparam int          V_TICKS[NV] = '{1, 2, 256, 4096, 65280};

  always #4 clk = ~clk;

  cyc_irq_timer u_cyc_irq_timer (
    .clk(clk), .reset_n(reset_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .m2_rise(m2_rise), .irq(irq)
  );

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s irq=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      m2_rise = 1'b1;
      repeat (n) @(negedge clk);
      m2_rise = 1'b0;
    end
  endtask

  task automatic arm(input logic [15:0] v);
    wr(HI, 8'h00);
    wr(LO, v[7:0]);
    wr(HI, v[15:8]);
  endtask

  initial begin
    reset_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0; m2_rise = 1'b0;
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 irq low in reset");
    reset_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 irq low after reset");
    ticks(300);
    chk(1'b0, "R1 disabled after reset, ticks ignored");

    // Vector loop
    for (int i = 0; i < NV; i++) begin
      arm(V_START[i]);
      chk(1'b0, "R4 ack before arming");
      ticks(V_TICKS[i] - 1);
      chk(1'b0, "R6 no irq one tick before wrap");
      ticks(1);
      chk(1'b1, "R6 irq on wrap");
    end

    // R7 sticky through ticks and writes
    ticks(10);
    chk(1'b1, "R7 irq holds over ticks");
    wr(LO, 8'h12);
    chk(1'b1, "R7 irq holds over low write");
    wr(HI, 8'h55);
    chk(1'b1, "R7 irq holds over nonzero high write");
    wr(HI, 8'h00);
    chk(1'b0, "R4 zero high write clears irq");

    // R5 disabled ticks leave the low byte alone
    wr(LO, 8'hFF);
    wr(HI, 8'hFF);
    wr(HI, 8'h00);
    ticks(300);
    chk(1'b0, "R5 no irq while disabled");
    wr(HI, 8'hFF);
    ticks(1);
    chk(1'b1, "R5 low byte unchanged while disabled");

    // R6 counter keeps running after the wrap
    arm(16'hFFFF);
    ticks(1);
    ticks(5);
    wr(HI, 8'h00);
    wr(HI, 8'hFF);
    ticks(250);
    chk(1'b0, "R6 counter continued after wrap (no early irq)");
    ticks(1);
    chk(1'b1, "R6 counter continued after wrap (irq at FFFF+1)");

    // R2 low write leaves enable in place
    wr(HI, 8'h00);
    wr(HI, 8'hFF);
    wr(LO, 8'hFE);
    ticks(1);
    chk(1'b0, "R2 low write keeps enable, one tick short");
    ticks(1);
    chk(1'b1, "R2 low write keeps enable, wrap");

    // R8 write beats a same-cycle tick
    arm(16'hFF00);
    cpu_addr = LO; cpu_wdata = 8'hFE; cpu_we = 1'b1; m2_rise = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0; m2_rise = 1'b0;
    ticks(1);
    chk(1'b0, "R8 tick in write cycle discarded");
    ticks(1);
    chk(1'b1, "R8 wrap after loaded value");

    // R9 near-miss addresses ignored
    arm(16'hFFFE);
    wr(16'h4102, 8'h00);
    wr(16'h4001, 8'h00);
    wr(16'hC101, 8'h00);
    wr(16'h4000, 8'h00);
    ticks(1);
    chk(1'b0, "R9 foreign writes ignored, one tick short");
    ticks(1);
    chk(1'b1, "R9 foreign writes ignored, wrap");

    // R1 reset clears a pending irq
    reset_n = 1'b0;
    @(negedge clk);
    chk(1'b0, "R1 reset clears irq");
    reset_n = 1'b1;
    repeat (3) @(negedge clk);
    ticks(20);
    chk(1'b0, "R1 still disabled after second reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired irq=%0b expected=done", irq);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule